// File: doc/BRIEF.md
# DMA Channel Request Arbiter

This block sits in front of a shared DMA transfer engine and decides which of eight channels may use it next. Each channel picks one request source: a self-generated request that stays on while the channel still has transfers left, a request line from an on-chip peripheral, or, on channels 0 to 3 only, an off-chip request pin. Each pin passes through a two-flop synchronizer and then a detector. The detector can be set to a low level, a high level, a rising edge or a falling edge. A master enable and a per-channel enable gate every request.

The arbiter issues a one-hot grant and holds it while the engine moves one transfer unit. The engine reports the end of that unit with `unit_done`, which serves as the engine's ready for the next grant. The arbiter runs a new round only at that point, or when no channel holds a grant. A one-cycle acknowledge marks the first cycle of every new grant. The priority rule can be changed at run time: fixed, where the lower channel number wins, or rotating, where the channel served last drops to the lowest rank.

Top module: `dma_req_arbiter`

## Requirements
- R1: With `rr_mode` low, the requesting channel with the lowest index wins: channel 0 is the highest priority and channel 7 the lowest.
- R2: With `rr_mode` high, the search starts at the channel after the one granted most recently and wraps past 7 to 0. After reset the most recent channel counts as 7. The mode may change between any two rounds.
- R3: A new round is run only on a cycle where `unit_done` is high or no grant is held. Otherwise `grant` keeps its value, even if a higher-ranked channel starts requesting. `unit_done` while idle has no effect.
- R4: `grant` is one-hot, or zero when no channel requests at a round. It is zero after reset. `ack` is high for the winning channel only in the first cycle of each new grant, including a re-grant to the same channel.
- R5: A channel requests only while `glob_en` and its `ch_en` bit are both 1.
- R6: The source code for channel n is `src_sel[2n+1:2n]`: 0 = self request (follows `auto_live[n]`), 1 = peripheral (`periph_req[n]`), 2 = external pin, 3 = never requests.
- R7: Channels 4 to 7 have no external pin. Source code 2 on them never produces a request.
- R8: The detect code for pin n is `ext_mode[2n+1:2n]`: 0 = low level, 1 = high level, 2 = rising edge, 3 = falling edge. A level request follows the synchronized pin and is not stored.
- R9: A detected edge is held until the channel's grant starts or the channel is disabled. It produces exactly one grant per edge.
- R10: Each pin passes two synchronizer flops. Starting from idle, a pin change set up before rising edge k yields a grant at edge k+2 and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| glob_en | input | 1 | Master request enable |
| ch_en | input | 8 | Per-channel enable |
| src_sel | input | 16 | Two-bit source code per channel |
| auto_live | input | 8 | Self-request channels still have transfers left |
| periph_req | input | 8 | Peripheral request lines |
| ext_pin | input | 4 | Asynchronous request pins, channels 0 to 3 |
| ext_mode | input | 8 | Two-bit detect code per pin |
| rr_mode | input | 1 | 0 fixed priority, 1 rotating |
| unit_done | input | 1 | Engine finished the current unit; ready for the next grant |
| grant | output | 8 | One-hot grant, held for one unit |
| ack | output | 8 | One-cycle pulse on the first cycle of a grant |

## Verification
The bench targets the rotating pointer's wrap from channel 7 to 0 and mode changes between rounds. A design that got these wrong would repeat a channel or skip one. It raises a higher-priority request while a grant is held; a design that re-arbitrated early would drop that grant mid-unit. For edge detection, the bench lets an edge arrive while another channel holds the engine, then checks for exactly one delayed grant. A design that did not store edges would lose the edge, and one that never cleared the stored edge would grant forever. The bench also counts the synchronizer latency edge by edge and drives the pin source on a channel with no pin, to catch early grants and phantom requests.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  typedef enum logic [1:0] {
    SRC_AUTO   = 2'd0,
    SRC_PERIPH = 2'd1,
    SRC_EXT    = 2'd2,
    SRC_OFF    = 2'd3
  } src_e;

  typedef enum logic [1:0] {
    DET_LOW  = 2'd0,
    DET_HIGH = 2'd1,
    DET_RISE = 2'd2,
    DET_FALL = 2'd3
  } det_e;
endpackage

// File: rtl/dma_ext_detect.sv
module dma_ext_detect
  import dma_arb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  det_e mode,
  input  logic allow,
  input  logic take,
  output logic req
);
  logic sync1_q, sync2_q, prev_q, held_q;
  logic edge_hit, is_edge, level_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      prev_q  <= 1'b0;
    end else begin
      sync1_q <= pin;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
    end
  end

  always_comb begin
    is_edge = (mode == DET_RISE) || (mode == DET_FALL);
    unique case (mode)
      DET_RISE: edge_hit = sync2_q & ~prev_q;
      DET_FALL: edge_hit = ~sync2_q & prev_q;
      default:  edge_hit = 1'b0;
    endcase
    level_hit = (mode == DET_HIGH) ? sync2_q : ~sync2_q;
  end

  // stored edge: dropped when the grant starts or the channel is disabled
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_q <= 1'b0;
    else        held_q <= allow & ~take & (held_q | edge_hit);
  end

  assign req = allow & (is_edge ? (held_q | edge_hit) : level_hit);
endmodule

// File: rtl/dma_src_mux.sv
module dma_src_mux
  import dma_arb_pkg::*;
(
  input  logic allow,
  input  src_e src,
  input  logic auto_live,
  input  logic periph,
  input  logic ext_req,
  output logic req
);
  always_comb begin
    unique case (src)
      SRC_AUTO:   req = allow & auto_live;
      SRC_PERIPH: req = allow & periph;
      SRC_EXT:    req = ext_req;
      default:    req = 1'b0;
    endcase
  end
endmodule

// File: rtl/dma_pick.sv
module dma_pick #(
  parameter int N = 8,
  localparam int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] req,
  input  logic         rotate,
  input  logic [W-1:0] last,
  output logic [N-1:0] win_oh,
  output logic [W-1:0] win_idx,
  output logic         any
);
  always_comb begin
    int base;
    logic found;
    win_oh  = '0;
    win_idx = '0;
    found   = 1'b0;
    base    = 0;
    if (rotate) base = (int'(last) >= N - 1) ? 0 : int'(last) + 1;
    for (int i = 0; i < N; i++) begin
      int j;
      j = base + i;
      if (j >= N) j = j - N;
      if (!found && req[j]) begin
        found     = 1'b1;
        win_oh[j] = 1'b1;
        win_idx   = W'(j);
      end
    end
    any = found;
  end
endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter
  import dma_arb_pkg::*;
#(
  parameter int N_CH  = 8,
  parameter int N_EXT = 4,
  localparam int W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 glob_en,
  input  logic [N_CH-1:0]      ch_en,
  input  logic [2*N_CH-1:0]    src_sel,
  input  logic [N_CH-1:0]      auto_live,
  input  logic [N_CH-1:0]      periph_req,
  input  logic [N_EXT-1:0]     ext_pin,
  input  logic [2*N_EXT-1:0]   ext_mode,
  input  logic                 rr_mode,
  input  logic                 unit_done,
  output logic [N_CH-1:0]      grant,
  output logic [N_CH-1:0]      ack
);
  logic [N_CH-1:0] req_vec, ext_req, win_oh, grant_q, ack_q;
  logic [W-1:0]    win_idx, last_q;
  logic            any_req, load;

  assign load = (grant_q == '0) | unit_done;

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    logic allow;
    assign allow = glob_en & ch_en[i];
    if (i < N_EXT) begin : g_pin
      dma_ext_detect u_det (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (ext_pin[i]),
        .mode  (det_e'(ext_mode[2*i +: 2])),
        .allow (allow),
        .take  (load & win_oh[i]),
        .req   (ext_req[i])
      );
    end else begin : g_nopin
      assign ext_req[i] = 1'b0;
    end
    dma_src_mux u_mux (
      .allow     (allow),
      .src       (src_e'(src_sel[2*i +: 2])),
      .auto_live (auto_live[i]),
      .periph    (periph_req[i]),
      .ext_req   (ext_req[i]),
      .req       (req_vec[i])
    );
  end

  dma_pick #(.N(N_CH)) u_pick (
    .req     (req_vec),
    .rotate  (rr_mode),
    .last    (last_q),
    .win_oh  (win_oh),
    .win_idx (win_idx),
    .any     (any_req)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_q <= '0;
      ack_q   <= '0;
      last_q  <= W'(N_CH - 1);
    end else if (load) begin
      grant_q <= win_oh;
      ack_q   <= win_oh;
      if (any_req) last_q <= win_idx;
    end else begin
      ack_q <= '0;
    end
  end

  assign grant = grant_q;
  assign ack   = ack_q;
endmodule

// File: rtl/dma_arb_chk.sv
module dma_arb_chk #(
  parameter int N_CH  = 8,
  parameter int N_EXT = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 glob_en,
  input logic                 rr_mode,
  input logic                 unit_done,
  input logic [2*N_CH-1:0]    src_sel,
  input logic [N_CH-1:0]      req_vec,
  input logic [N_CH-1:0]      grant,
  input logic [N_CH-1:0]      ack
);
  localparam logic [N_CH-1:0] ONE = N_CH'(1);

  assert_grant_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  assert_ack_in_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ack & ~grant) == '0);

  assert_grant_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0 && !unit_done) |=> ($stable(grant) && ack == '0));

  assert_fixed_order_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ack != '0 && !$past(rr_mode)) |-> (($past(req_vec) & (ack - ONE)) == '0));

  assert_ack_from_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack != '0) |-> (($past(req_vec) & ack) != '0 && $past(glob_en)));

  for (genvar k = N_EXT; k < N_CH; k++) begin : g_nopin
    assert_no_pin_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ack[k] |-> ($past(src_sel[2*k +: 2]) != 2'd2));
  end
endmodule

bind dma_req_arbiter dma_arb_chk #(.N_CH(N_CH), .N_EXT(N_EXT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .glob_en   (glob_en),
  .rr_mode   (rr_mode),
  .unit_done (unit_done),
  .src_sel   (src_sel),
  .req_vec   (req_vec),
  .grant     (grant),
  .ack       (ack)
);

// File: tb/dma_req_arbiter_tb.sv
`timescale 1ns/100ps
module dma_req_arbiter_tb;
  logic clk = 1'b0;
  logic rst_n, glob_en, rr_mode, unit_done;
  logic [7:0]  ch_en, auto_live, periph_req, grant, ack;
  logic [15:0] src_sel;
  logic [3:0]  ext_pin;
  logic [7:0]  ext_mode;
  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dma_req_arbiter u_dut (
    .clk(clk), .rst_n(rst_n), .glob_en(glob_en), .ch_en(ch_en),
    .src_sel(src_sel), .auto_live(auto_live), .periph_req(periph_req),
    .ext_pin(ext_pin), .ext_mode(ext_mode), .rr_mode(rr_mode),
    .unit_done(unit_done), .grant(grant), .ack(ack)
  );

  // {rr_mode, request pattern, expected grant}, each applied from idle
  localparam logic [16:0] VEC [12] = '{
    {1'b0, 8'h0C, 8'h04}, {1'b0, 8'h81, 8'h01}, {1'b0, 8'hF0, 8'h10},
    {1'b1, 8'h11, 8'h01}, {1'b1, 8'h03, 8'h02}, {1'b1, 8'h03, 8'h01},
    {1'b1, 8'h80, 8'h80}, {1'b1, 8'h81, 8'h01}, {1'b0, 8'h00, 8'h00},
    {1'b1, 8'h60, 8'h20}, {1'b0, 8'h60, 8'h20}, {1'b1, 8'h21, 8'h01}
  };

  task automatic tick(int n = 1);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_unit();
    unit_done = 1'b1;
    tick();
    unit_done = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; glob_en = 1'b1; ch_en = 8'hFF; src_sel = 16'h5555;
    auto_live = '0; periph_req = '0; ext_pin = '0; ext_mode = '0;
    rr_mode = 1'b0; unit_done = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick();
    chk("R4 reset grant", grant, 8'h00);
    chk("R4 reset ack", ack, 8'h00);

    // R1/R2 table walk
    for (int v = 0; v < 12; v++) begin
      rr_mode = VEC[v][16];
      periph_req = VEC[v][15:8];
      tick();
      chk($sformatf("R1 R2 vec%0d grant", v), grant, VEC[v][7:0]);
      chk($sformatf("R4 vec%0d ack", v), ack, VEC[v][7:0]);
      periph_req = '0;
      finish_unit();
      chk($sformatf("R4 vec%0d release", v), grant, 8'h00);
    end

    // R3 hold until unit_done
    rr_mode = 1'b0; periph_req = 8'h06;
    tick();
    chk("R3 first grant", grant, 8'h02);
    tick();
    chk("R4 ack one cycle", ack, 8'h00);
    periph_req = 8'h07;
    tick(2);
    chk("R3 held against ch0", grant, 8'h02);
    unit_done = 1'b1;
    tick();
    chk("R3 regrant ch0", grant, 8'h01);
    chk("R4 ack new grant", ack, 8'h01);
    tick();
    chk("R4 ack on repeat grant", ack, 8'h01);
    periph_req = '0;
    tick();
    chk("R3 release", grant, 8'h00);
    tick();
    chk("R3 done while idle", grant, 8'h00);
    unit_done = 1'b0;

    // R5 enables
    glob_en = 1'b0; periph_req = 8'hFF;
    tick(2);
    chk("R5 master off", grant, 8'h00);
    glob_en = 1'b1; ch_en = 8'hFE;
    tick();
    chk("R5 channel off", grant, 8'h02);
    periph_req = '0;
    finish_unit();
    ch_en = 8'hFF;

    // R6 source codes
    src_sel = 16'hFFFF; src_sel[5:4] = 2'd0; auto_live = 8'h04;
    tick();
    chk("R6 self request", grant, 8'h04);
    auto_live = 8'h08;
    finish_unit();
    chk("R6 self expired", grant, 8'h00);
    periph_req = 8'h08;
    tick();
    chk("R6 source off", grant, 8'h00);
    periph_req = '0; auto_live = '0;

    // R7 no pin above channel 3
    src_sel = 16'hFFFF; src_sel[11:10] = 2'd2;
    ext_mode = 8'h55; ext_pin = 4'hF;
    tick(4);
    chk("R7 pin source on ch5", grant, 8'h00);
    src_sel[3:2] = 2'd2;
    tick();
    chk("R8 high level ch1", grant, 8'h02);
    src_sel[11:10] = 2'd3;
    ext_pin = 4'h0;
    tick(3);
    chk("R3 held after pin drop", grant, 8'h02);
    finish_unit();
    chk("R8 level not stored", grant, 8'h00);

    // R10 synchronizer latency
    ext_pin[1] = 1'b1;
    tick();
    chk("R10 edge k", grant, 8'h00);
    tick();
    chk("R10 edge k+1", grant, 8'h00);
    tick();
    chk("R10 edge k+2", grant, 8'h02);
    chk("R10 ack", ack, 8'h02);
    ext_pin[1] = 1'b0;
    tick(3);
    finish_unit();
    chk("R8 high released", grant, 8'h00);

    // R8 low level
    ext_mode = 8'h51;
    tick();
    chk("R8 low level", grant, 8'h02);
    ext_pin[1] = 1'b1;
    tick(3);
    finish_unit();
    chk("R8 low released", grant, 8'h00);

    // R9 rising edge
    ext_mode = 8'h59; ext_pin[1] = 1'b0;
    tick(3);
    chk("R9 falling ignored in rise mode", grant, 8'h00);
    ext_pin[1] = 1'b1;
    tick(3);
    chk("R9 rise grant", grant, 8'h02);
    finish_unit();
    chk("R9 one grant per edge", grant, 8'h00);

    // R9 edge stored while another channel holds the engine
    src_sel[1:0] = 2'd1; periph_req = 8'h01;
    tick();
    chk("R9 ch0 holds", grant, 8'h01);
    ext_pin[1] = 1'b0;
    tick(3);
    ext_pin[1] = 1'b1;
    tick(4);
    chk("R3 ch0 still holds", grant, 8'h01);
    periph_req = '0;
    finish_unit();
    chk("R9 stored edge granted", grant, 8'h02);
    finish_unit();
    chk("R9 store cleared by grant", grant, 8'h00);

    // R9 falling edge
    ext_mode = 8'h5D; ext_pin[1] = 1'b0;
    tick(3);
    chk("R9 fall grant", grant, 8'h02);
    finish_unit();
    chk("R9 fall consumed", grant, 8'h00);

    // R9 disable drops a stored edge
    ext_pin[1] = 1'b1;
    tick(3);
    periph_req = 8'h01;
    tick();
    ext_pin[1] = 1'b0;
    tick(4);
    ch_en = 8'hFD;
    tick();
    ch_en = 8'hFF; periph_req = '0;
    finish_unit();
    chk("R9 store dropped on disable", grant, 8'h00);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got hang expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule